// File: doc/BRIEF.md
# Pipelined Fixed-Point Natural Logarithm

This block computes the natural logarithm of an unsigned 32-bit integer and returns it as a signed fixed-point number with 16 fraction bits. It is meant to sit in front of an exponential-distribution sampler, where a uniform integer is turned into `-ln(u)`.

The input is first normalised. The position of its highest set bit gives an integer exponent `e`, and a left shift by the leading-zero count gives a mantissa `1.m` in [1,2). The top 8 bits of `m` select two neighbouring entries of a 257-point table of `log2(1 + k/256)` held in Q0.18. The next 8 bits of `m` interpolate linearly between those two entries. Adding `e` gives `log2(x)`, and a single constant multiply by ln(2) turns that into `ln(x)`.

Because of the normalisation, a small table covers the whole 32-bit range. The datapath has five register stages, accepts a new sample on every clock, and carries a valid bit beside the data.

Top module: `fxl_ln32`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_err` and `out_data` are all zero after that edge.
- R2: A sample accepted with `in_valid` high on edge n sets `out_valid` high right after edge n+4 (five register stages). An idle input cycle gives an idle output cycle at the same distance.
- R3: A new sample is accepted on every clock, so back-to-back inputs give back-to-back outputs in the same order.
- R4: For a nonzero input x, `out_data` is a 22-bit two's-complement value with 16 fraction bits, and |out_data/65536 − ln(x)| ≤ 2^-14.
- R5: Input 1 gives `out_data` exactly 0.
- R6: Input 0 gives `out_err` = 1 and `out_data` = −2^21 (bit 21 set, all other bits clear). Any nonzero input gives `out_err` = 0, and `out_err` is never high without `out_valid`.
- R7: Results for nonzero inputs are never negative, and never decrease as the input increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a sample to process |
| in_data | input | 32 | Unsigned integer operand |
| out_valid | output | 1 | Marks `out_data` and `out_err` as a result |
| out_data | output | 22 | ln of the operand, signed Q6.16 |
| out_err | output | 1 | Operand was zero; `out_data` is saturated |

## Verification
The bound checker watches these properties on every cycle:
- the five-stage alignment of the valid bit, and that the error flag matches a zero operand from five edges before;
- the saturated code that comes with the error flag;
- the sign of every non-error result;
- the quiet state under reset;
- a set leading bit in the normalised mantissa.

Only the bench scenarios can show numerical accuracy against a real-valued logarithm and monotonic order over consecutive inputs. They cover an exhaustive sweep of small operands, every power of two and its predecessor, and a long pseudo-random run with irregular gaps.

// File: rtl/fxl_pkg.sv
package fxl_pkg;

  // round(log2(1 + k / 2^idx_w) * 2^frac_w), computed by repeated squaring
  function automatic longint log2_frac(input int k, input int idx_w, input int frac_w);
    logic [63:0] x;
    longint      res;
    x   = (64'd1 << 30) + (64'(k) << (30 - idx_w));
    res = 0;
    for (int b = 0; b < frac_w + 2; b++) begin
      x   = (x * x) >> 30;
      res = res << 1;
      if (x >= (64'd2 << 30)) begin
        res = res | 1;
        x   = x >> 1;
      end
    end
    return (res + 2) >>> 2;
  endfunction

endpackage

// File: rtl/fxl_norm.sv
module fxl_norm #(
  parameter int IN_W  = 32,
  parameter int IDX_W = 8,
  parameter int FRAC_W = 8,
  localparam int EXP_W = $clog2(IN_W),
  localparam int TOP_W = 1 + IDX_W + FRAC_W
) (
  input  logic [IN_W-1:0]   x,
  output logic [EXP_W-1:0]  msb_pos,
  output logic [TOP_W-1:0]  mant_top,
  output logic              is_zero
);
  localparam int DROP = IN_W - TOP_W;

  always_comb begin
    msb_pos = '0;
    for (int i = 0; i < IN_W; i++)
      if (x[i]) msb_pos = i[EXP_W-1:0];
    mant_top = TOP_W'((x << (EXP_W'(IN_W - 1) - msb_pos)) >> DROP);
    is_zero  = (x == '0);
  end
endmodule

// File: rtl/fxl_log2_rom.sv
module fxl_log2_rom #(
  parameter int IDX_W = 8,
  parameter int TAB_W = 18
) (
  input  logic [IDX_W-1:0] idx,
  output logic [TAB_W:0]   lo,
  output logic [TAB_W:0]   hi
);
  localparam int N = (1 << IDX_W) + 1;
  logic [TAB_W:0] tab [N];

  for (genvar k = 0; k < N; k++) begin : g_tab
    localparam logic [TAB_W:0] V = (TAB_W+1)'(fxl_pkg::log2_frac(k, IDX_W, TAB_W));
    assign tab[k] = V;
  end

  always_comb begin
    lo = tab[idx];
    hi = tab[(IDX_W+1)'(idx) + 1'b1];
  end
endmodule

// File: rtl/fxl_to_ln.sv
module fxl_to_ln #(
  parameter int L2_W   = 24,
  parameter int TAB_W  = 18,
  parameter int OUT_W  = 22,
  parameter int OUT_FR = 16,
  parameter int LN2_FR = 20,
  parameter logic [LN2_FR-1:0] LN2_K = 20'd726818
) (
  input  logic [L2_W-1:0]  l2,
  input  logic             zero,
  output logic [OUT_W-1:0] y
);
  localparam int PW = L2_W + LN2_FR;
  localparam int SH = TAB_W + LN2_FR - OUT_FR;
  localparam logic [PW-1:0] HALF = PW'(1) << (SH - 1);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(l2) * PW'(LN2_K);
    y    = zero ? MOST_NEG : OUT_W'((prod + HALF) >> SH);
  end
endmodule

// File: rtl/fxl_ln32.sv
module fxl_ln32 #(
  parameter int IN_W   = 32,
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 8,
  parameter int TAB_W  = 18,
  parameter int OUT_W  = 22,
  parameter int OUT_FR = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_err
);
  localparam int EXP_W = $clog2(IN_W);
  localparam int TOP_W = 1 + IDX_W + FRAC_W;
  localparam int STP_W = TAB_W + 1 + FRAC_W;
  localparam int L2_W  = EXP_W + TAB_W + 1;

  // stage 1: normalise
  logic [EXP_W-1:0] norm_exp;
  logic [TOP_W-1:0] norm_top;
  logic             norm_zero;
  logic             s1_valid, s1_zero;
  logic [EXP_W-1:0] s1_exp;
  logic [TOP_W-1:0] s1_mant;

  fxl_norm #(.IN_W(IN_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_norm (
    .x(in_data), .msb_pos(norm_exp), .mant_top(norm_top), .is_zero(norm_zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0; s1_zero <= 1'b0; s1_exp <= '0; s1_mant <= '0;
    end else begin
      s1_valid <= in_valid; s1_zero <= norm_zero; s1_exp <= norm_exp; s1_mant <= norm_top;
    end
  end

  // stage 2: table lookup
  logic [IDX_W-1:0]  s1_idx;
  logic [FRAC_W-1:0] s1_f;
  logic [TAB_W:0]    rom_lo, rom_hi;
  assign s1_idx = s1_mant[TOP_W-2 -: IDX_W];
  assign s1_f   = s1_mant[FRAC_W-1:0];

  fxl_log2_rom #(.IDX_W(IDX_W), .TAB_W(TAB_W)) u_rom (
    .idx(s1_idx), .lo(rom_lo), .hi(rom_hi));

  logic              s2_valid, s2_zero;
  logic [EXP_W-1:0]  s2_exp;
  logic [TAB_W:0]    s2_lo, s2_hi;
  logic [FRAC_W-1:0] s2_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0; s2_zero <= 1'b0; s2_exp <= '0;
      s2_lo <= '0; s2_hi <= '0; s2_f <= '0;
    end else begin
      s2_valid <= s1_valid; s2_zero <= s1_zero; s2_exp <= s1_exp;
      s2_lo <= rom_lo; s2_hi <= rom_hi; s2_f <= s1_f;
    end
  end

  // stage 3: interpolation step
  logic [STP_W-1:0] step_c;
  assign step_c = STP_W'(s2_hi - s2_lo) * STP_W'(s2_f);

  logic             s3_valid, s3_zero;
  logic [EXP_W-1:0] s3_exp;
  logic [TAB_W:0]   s3_base;
  logic [STP_W-1:0] s3_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_valid <= 1'b0; s3_zero <= 1'b0; s3_exp <= '0; s3_base <= '0; s3_step <= '0;
    end else begin
      s3_valid <= s2_valid; s3_zero <= s2_zero; s3_exp <= s2_exp;
      s3_base <= s2_lo; s3_step <= step_c;
    end
  end

  // stage 4: log2 = exponent + interpolated fraction
  logic            s4_valid, s4_zero;
  logic [L2_W-1:0] s4_l2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_valid <= 1'b0; s4_zero <= 1'b0; s4_l2 <= '0;
    end else begin
      s4_valid <= s3_valid; s4_zero <= s3_zero;
      s4_l2 <= {1'b0, s3_exp, {TAB_W{1'b0}}} + L2_W'(s3_base) + L2_W'(s3_step >> FRAC_W);
    end
  end

  // stage 5: scale to natural log, saturate zero operand
  logic [OUT_W-1:0] ln_c;
  fxl_to_ln #(.L2_W(L2_W), .TAB_W(TAB_W), .OUT_W(OUT_W), .OUT_FR(OUT_FR)) u_ln (
    .l2(s4_l2), .zero(s4_zero), .y(ln_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_err <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= s4_valid; out_err <= s4_valid & s4_zero; out_data <= ln_c;
    end
  end
endmodule

// File: rtl/fxl_ln32_chk.sv
module fxl_ln32_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 22,
  parameter int TOP_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_err,
  input logic             s1_valid,
  input logic             s1_zero,
  input logic [TOP_W-1:0] s1_mant
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};
  logic [2:0] warm;

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 3'd5) warm <= warm + 3'd1;
  end

  assert_quiet_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_data == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd5) |-> (out_valid == $past(in_valid, 5)));

  assert_err_matches_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd5 && out_valid) |-> (out_err == ($past(in_data, 5) == '0)));

  assert_err_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);

  assert_err_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_data == MOST_NEG));

  assert_result_nonneg_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err) |-> !out_data[OUT_W-1]);

  assert_norm_leading_one_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_zero) |-> s1_mant[TOP_W-1]);
endmodule

bind fxl_ln32 fxl_ln32_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .TOP_W(TOP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .out_err(out_err),
  .s1_valid(s1_valid), .s1_zero(s1_zero), .s1_mant(s1_mant));

// File: tb/test_fxl_ln32.sv
`timescale 1ns/1ps
module test_fxl_ln32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [21:0] out_data;
  logic        out_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fxl_ln32 i_fxl_ln32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err));

  // input history: entry 4 is the sample accepted five edges ago
  logic        hv [5];
  logic [31:0] hd [5];
  always @(posedge clk) begin
    for (int i = 4; i > 0; i--) begin
      hv[i] <= rst ? 1'b0 : hv[i-1];
      hd[i] <= hd[i-1];
    end
    hv[0] <= rst ? 1'b0 : in_valid;
    hd[0] <= in_data;
  end

  bit          have_last = 1'b0;
  logic [31:0] last_x;
  int          last_y;

  always @(negedge clk) begin
    if (rst) begin
      checks++;
      if (out_valid || out_err || out_data != '0) begin
        failures++;
        $display("FAIL R1 reset state got v=%0b e=%0b d=%0d expected 0 0 0",
                 out_valid, out_err, out_data);
      end
    end else if (out_valid || hv[4]) begin
      checks++;
      if (out_valid != hv[4]) begin
        failures++;
        $display("FAIL R2/R3 out_valid got=%0b expected=%0b", out_valid, hv[4]);
      end else begin
        int  y;
        real got, ref_v, err;
        y = $signed(out_data);
        if (hd[4] == 0) begin
          checks++;
          if (!out_err || out_data != 22'h200000) begin
            failures++;
            $display("FAIL R6 zero input got err=%0b d=%0d expected err=1 d=%0d",
                     out_err, y, -2097152);
          end
        end else begin
          got   = y / 65536.0;
          ref_v = $ln(real'(hd[4]));
          err   = got - ref_v;
          if (err < 0.0) err = -err;
          checks++;
          if (out_err || err > 1.0/16384.0) begin
            failures++;
            $display("FAIL R4 x=%0d got=%f err=%0b expected=%f err=0",
                     hd[4], got, out_err, ref_v);
          end
          if (hd[4] == 1) begin
            checks++;
            if (y != 0) begin
              failures++;
              $display("FAIL R5 x=1 got=%0d expected=0", y);
            end
          end
          checks++;
          if (y < 0 || (have_last && hd[4] > last_x && y < last_y)) begin
            failures++;
            $display("FAIL R7 x=%0d got=%0d expected>=%0d (prev x=%0d)",
                     hd[4], y, (have_last && hd[4] > last_x) ? last_y : 0, last_x);
          end
          have_last = 1'b1;
          last_x = hd[4];
          last_y = y;
        end
      end
    end
  end

  task automatic send(input logic [31:0] x);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_data  = x;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_data  = 32'hDEAD_BEEF;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    repeat (4) @(posedge clk);   // R1 checked while held in reset
    #2 rst = 1'b0;
    idle(3);
    // R6 zero input, R5 unity
    send(32'd0); send(32'd1); idle(6);
    // R3 back-to-back exhaustive sweep of small operands, R7 ordering
    have_last = 1'b0;
    for (int x = 1; x <= 4096; x++) send(32'(x));
    idle(6);
    // R4 powers of two and their predecessors
    have_last = 1'b0;
    for (int k = 1; k < 32; k++) begin
      send((32'd1 << k) - 32'd1);
      send(32'd1 << k);
    end
    send(32'hFFFF_FFFF);
    idle(6);
    // R2 pseudo-random operands with irregular idle gaps, zero mixed in
    have_last = 1'b0;
    s = 32'h1234_5678;
    for (int n = 0; n < 15000; n++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      have_last = 1'b0;
      if (n % 3 == 2) idle(1 + (s[2:0] == 3'd0 ? 1 : 0));
      else if (n % 997 == 0) send(32'd0);
      else send(s >> s[27:24]);
    end
    idle(10);
    finish_run();
  end
endmodule